// File: doc/BRIEF.md
# DMA Channel Control and Status Register Block

This block holds the control and status registers of one DMA channel. Software reaches it over a simple register port (address, write data, write strobe, combinational read data). A command register takes one-shot request bits, and a small state machine turns them into channel states: idle, running, paused, waiting to resume and stopping. The block drives the transfer engine's start, run and stop-request lines, and it takes the engine's completion, beat-boundary and error inputs back in.

Completion and error events set sticky interrupt flags. Software clears a flag by writing one to it. Each flag is masked by its own enable, and the masked flags are merged into a single interrupt line. The cause of an error is kept in a separate register, split into three causes: read response, write response and read data poison. A clear command puts every register back to its reset value.

The register offsets are parameters, with these defaults: status at 0x0, interrupt enable at 0x4, error cause at 0x8 and command at 0xC.

Top module: `dmach_ctl_regs`

## Requirements
- R1: After reset the channel is idle, with `eng_run`, `eng_stop_req`, `eng_start` and `irq` low. The status, interrupt enable and error cause registers all read zero.
- R2: The command register takes these one-shot bits: bit0 enable, bit1 clear, bit2 disable, bit3 stop, bit4 pause, bit5 resume. It always reads zero, and so does any unmapped offset. When one write sets several bits, only the highest-priority bit is acted on, in the order clear, stop, disable, pause, resume, enable. If the state ignores that bit, the write has no effect.
- R3: Enable in the idle state moves the channel to running on the next cycle and raises `eng_start` for exactly one cycle. It also clears status bits 16 to 19 and the error cause register. Enable in any other state has no effect.
- R4: Pause moves a running channel to paused: status bit20 goes high and `eng_run` goes low. Pause in any other state has no effect.
- R5: Resume moves a paused channel into resume-wait (status bit21) for RESUME_LAT cycles, with `eng_run` low, and then to running. Resume in any other state has no effect.
- R6: Stop in the running state enters stopping. There `eng_stop_req` stays high until `eng_beat_end` or `eng_done` arrives, and the channel then goes idle with stopped status bit19 set. Stop in the paused or resume-wait state goes idle with bit19 set on the next cycle. Stop in the idle state has no effect.
- R7: Disable in the running, paused or resume-wait state is held until the engine completes. The channel then goes idle with both done (bit16) and disabled (bit18) set. A later stop discards the held disable. Disable in the idle or stopping state has no effect.
- R8: When `eng_done` arrives in the running state, the channel goes idle, sets done status bit16 and sets sticky done flag bit0.
- R9: Any error input that arrives in the running or stopping state sends the channel to idle and sets error status bit17 and sticky error flag bit1. It also ORs its cause into the error cause register: bit16 for read response, bit17 for write response, bit18 for poison. Error inputs in any other state are ignored.
- R10: Writing ones to status bits 0 or 1 clears those flags. A write to the status register changes no other bit. If a flag is set by an event and cleared by a write in the same cycle, the flag stays set.
- R11: The interrupt enable register has bit0 for done and bit1 for error. `irq` is high in the same cycle whenever an enabled flag is set.
- R12: Clear, in any state, returns the state, status, flags, interrupt enables and error causes to their reset values.
- R13: In a cycle where the block accepts an engine error or completion, every command except clear is dropped. An error takes precedence over a completion that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| eng_start | output | 1 | One-cycle pulse when a transfer is launched |
| eng_run | output | 1 | Engine allowed to advance |
| eng_stop_req | output | 1 | Engine asked to halt at the next beat boundary |
| eng_beat_end | input | 1 | Engine reached a beat boundary |
| eng_done | input | 1 | Engine finished the command |
| eng_rd_resp_err | input | 1 | Read response error |
| eng_wr_resp_err | input | 1 | Write response error |
| eng_rd_poison | input | 1 | Poisoned read data |
| irq | output | 1 | Channel interrupt |

## Verification
Two kinds of same-cycle collision need the most care. The first is an engine event (completion or error) that lands in the same cycle as a command write. The second is a flag being set by an event in the same cycle as software writes one to clear it. The bench provokes both on purpose: it drives `eng_done` together with a pause write, `eng_done` together with a write-response error, and `eng_done` together with a write-one-to-clear of the done flag. It then checks that the event wins, that the error wins over completion, and that the flag stays set. A long random phase drives commands, engine inputs and register writes freely, so more collisions of this kind occur, and compares every output in every cycle against a behavioural model.

// File: rtl/dmach_ctl_pkg.sv
package dmach_ctl_pkg;

   typedef enum logic [2:0] {
      CH_IDLE,
      CH_RUN,
      CH_PAUSED,
      CH_RWAIT,
      CH_STOPPING
   } ch_state_e;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_ENABLE,
      OP_CLEAR,
      OP_DISABLE,
      OP_STOP,
      OP_PAUSE,
      OP_RESUME
   } ch_op_e;

   // command bit positions (software encodes these)
   localparam int CMD_ENABLE  = 0;
   localparam int CMD_CLEAR   = 1;
   localparam int CMD_DISABLE = 2;
   localparam int CMD_STOP    = 3;
   localparam int CMD_PAUSE   = 4;
   localparam int CMD_RESUME  = 5;
   localparam int CMD_BITS    = 6;

   // status bit positions
   localparam int ST_FLAG_DONE = 0;
   localparam int ST_FLAG_ERR  = 1;
   localparam int ST_DONE      = 16;
   localparam int ST_ERR       = 17;
   localparam int ST_DIS       = 18;
   localparam int ST_STOPPED   = 19;
   localparam int ST_PAUSED    = 20;
   localparam int ST_RWAIT     = 21;

   // error cause positions
   localparam int N_CAUSE   = 3;
   localparam int EI_BASE   = 16;

endpackage

// File: rtl/dmach_cmd_dec.sv
module dmach_cmd_dec
   import dmach_ctl_pkg::*;
(
   input  logic                cmd_wr,
   input  logic [CMD_BITS-1:0] cmd_bits,
   output ch_op_e              op
);

   // only the highest-priority bit is passed on
   always_comb begin
      op = OP_NONE;
      if (cmd_wr) begin
         if (cmd_bits[CMD_CLEAR])        op = OP_CLEAR;
         else if (cmd_bits[CMD_STOP])    op = OP_STOP;
         else if (cmd_bits[CMD_DISABLE]) op = OP_DISABLE;
         else if (cmd_bits[CMD_PAUSE])   op = OP_PAUSE;
         else if (cmd_bits[CMD_RESUME])  op = OP_RESUME;
         else if (cmd_bits[CMD_ENABLE])  op = OP_ENABLE;
      end
   end

endmodule

// File: rtl/dmach_chan_fsm.sv
module dmach_chan_fsm
   import dmach_ctl_pkg::*;
#(
   parameter int RESUME_LAT = 3
) (
   input  logic      clk,
   input  logic      rst_n,
   input  ch_op_e    op,
   input  logic      eng_done,
   input  logic      eng_beat_end,
   input  logic      eng_err_any,
   output ch_state_e state_q,
   output logic      st_done_q,
   output logic      st_err_q,
   output logic      st_dis_q,
   output logic      st_stp_q,
   output logic      done_evt,
   output logic      err_evt,
   output logic      start_evt,
   output logic      start_q
);

   localparam int CNT_W = (RESUME_LAT > 1) ? $clog2(RESUME_LAT) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESUME_LAT - 1);

   if (RESUME_LAT < 1) begin : g_bad_lat
      $error("RESUME_LAT must be at least 1");
   end

   ch_state_e        nxt;
   logic             n_done, n_err, n_dis, n_stp, n_pend, pend_q;
   logic [CNT_W-1:0] cnt_q, n_cnt;

   always_comb begin
      nxt       = state_q;
      n_done    = st_done_q;
      n_err     = st_err_q;
      n_dis     = st_dis_q;
      n_stp     = st_stp_q;
      n_pend    = pend_q;
      n_cnt     = cnt_q;
      done_evt  = 1'b0;
      err_evt   = 1'b0;
      start_evt = 1'b0;
      if (op == OP_CLEAR) begin
         nxt    = CH_IDLE;
         n_done = 1'b0;
         n_err  = 1'b0;
         n_dis  = 1'b0;
         n_stp  = 1'b0;
         n_pend = 1'b0;
         n_cnt  = '0;
      end else if (eng_err_any && (state_q == CH_RUN || state_q == CH_STOPPING)) begin
         nxt     = CH_IDLE;
         n_err   = 1'b1;
         n_pend  = 1'b0;
         err_evt = 1'b1;
      end else if (state_q == CH_RUN && eng_done) begin
         nxt      = CH_IDLE;
         n_done   = 1'b1;
         n_dis    = pend_q;
         n_pend   = 1'b0;
         done_evt = 1'b1;
      end else if (state_q == CH_STOPPING && (eng_beat_end || eng_done)) begin
         nxt   = CH_IDLE;
         n_stp = 1'b1;
      end else begin
         unique case (op)
            OP_ENABLE: begin
               if (state_q == CH_IDLE) begin
                  nxt       = CH_RUN;
                  n_done    = 1'b0;
                  n_err     = 1'b0;
                  n_dis     = 1'b0;
                  n_stp     = 1'b0;
                  start_evt = 1'b1;
               end
            end
            OP_STOP: begin
               if (state_q == CH_RUN) begin
                  nxt    = CH_STOPPING;
                  n_pend = 1'b0;
               end else if (state_q == CH_PAUSED || state_q == CH_RWAIT) begin
                  nxt    = CH_IDLE;
                  n_stp  = 1'b1;
                  n_pend = 1'b0;
               end
            end
            OP_DISABLE: begin
               if (state_q == CH_RUN || state_q == CH_PAUSED || state_q == CH_RWAIT)
                  n_pend = 1'b1;
            end
            OP_PAUSE: begin
               if (state_q == CH_RUN) nxt = CH_PAUSED;
            end
            OP_RESUME: begin
               if (state_q == CH_PAUSED) begin
                  nxt   = CH_RWAIT;
                  n_cnt = CNT_LOAD;
               end
            end
            default: ;
         endcase
         if (state_q == CH_RWAIT && nxt == CH_RWAIT) begin
            if (cnt_q == '0) nxt = CH_RUN;
            else             n_cnt = cnt_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= CH_IDLE;
         st_done_q <= 1'b0;
         st_err_q  <= 1'b0;
         st_dis_q  <= 1'b0;
         st_stp_q  <= 1'b0;
         pend_q    <= 1'b0;
         cnt_q     <= '0;
         start_q   <= 1'b0;
      end else begin
         state_q   <= nxt;
         st_done_q <= n_done;
         st_err_q  <= n_err;
         st_dis_q  <= n_dis;
         st_stp_q  <= n_stp;
         pend_q    <= n_pend;
         cnt_q     <= n_cnt;
         start_q   <= start_evt;
      end
   end

   // R3
   start_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> $past(state_q) == CH_IDLE);

   // R4
   pause_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_PAUSED && $past(state_q) != CH_PAUSED) |-> $past(state_q) == CH_RUN);

   // R5
   run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == CH_RUN && $past(state_q) != CH_RUN)
         |-> ($past(state_q) == CH_IDLE || $past(state_q) == CH_RWAIT));

   // R6
   stopped_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_stp_q) |-> ($past(state_q) == CH_STOPPING || $past(state_q) == CH_PAUSED
                           || $past(state_q) == CH_RWAIT));

endmodule

// File: rtl/dmach_irq_unit.sv
module dmach_irq_unit
   import dmach_ctl_pkg::*;
#(
   parameter bit IRQ_REGISTERED = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               done_evt,
   input  logic               err_evt,
   input  logic               start_evt,
   input  logic [N_CAUSE-1:0] err_cause,
   input  logic               ien_wr,
   input  logic [1:0]         ien_wdata,
   input  logic               w1c_wr,
   input  logic [1:0]         w1c_bits,
   output logic [1:0]         flags_q,
   output logic [1:0]         ien_q,
   output logic [N_CAUSE-1:0] einfo_q,
   output logic               irq
);

   logic [1:0] set_v, clr_v;
   assign set_v = {err_evt, done_evt};
   assign clr_v = w1c_wr ? w1c_bits : 2'b00;

   for (genvar i = 0; i < 2; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flags_q[i] <= 1'b0;
         else if (clr)        flags_q[i] <= 1'b0;
         else if (set_v[i])   flags_q[i] <= 1'b1;
         else if (clr_v[i])   flags_q[i] <= 1'b0;
      end
   end

   for (genvar c = 0; c < N_CAUSE; c++) begin : g_cause
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    einfo_q[c] <= 1'b0;
         else if (clr || start_evt)     einfo_q[c] <= 1'b0;
         else if (err_evt && err_cause[c]) einfo_q[c] <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ien_q <= 2'b00;
      else if (clr)    ien_q <= 2'b00;
      else if (ien_wr) ien_q <= ien_wdata;
   end

   logic irq_c;
   assign irq_c = |(flags_q & ien_q);

   if (IRQ_REGISTERED) begin : g_irq_ff
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_c;
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = irq_c;
   end

   // R8
   done_flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q[0]) |-> $past(done_evt));

   // R9
   err_flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q[1]) |-> $past(err_evt));

   // R10
   err_flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags_q[1]) |-> $past((w1c_wr && w1c_bits[1]) || clr));

   // R9
   einfo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|einfo_q) |-> $past(err_evt));

endmodule

// File: rtl/dmach_ctl_regs.sv
module dmach_ctl_regs
   import dmach_ctl_pkg::*;
#(
   parameter int          DATA_W         = 32,
   parameter int          ADDR_W         = 8,
   parameter int          OFS_STAT       = 'h0,
   parameter int          OFS_IEN        = 'h4,
   parameter int          OFS_EINFO      = 'h8,
   parameter int          OFS_CMD        = 'hC,
   parameter int          RESUME_LAT     = 3,
   parameter bit          IRQ_REGISTERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              reg_we,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              eng_start,
   output logic              eng_run,
   output logic              eng_stop_req,
   input  logic              eng_beat_end,
   input  logic              eng_done,
   input  logic              eng_rd_resp_err,
   input  logic              eng_wr_resp_err,
   input  logic              eng_rd_poison,
   output logic              irq
);

   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(OFS_IEN);
   localparam logic [ADDR_W-1:0] A_EINFO = ADDR_W'(OFS_EINFO);
   localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(OFS_CMD);

   if (DATA_W < ST_RWAIT + 1) begin : g_bad_dw
      $error("DATA_W too narrow for status layout");
   end
   if (OFS_STAT == OFS_IEN || OFS_STAT == OFS_EINFO || OFS_STAT == OFS_CMD ||
       OFS_IEN == OFS_EINFO || OFS_IEN == OFS_CMD || OFS_EINFO == OFS_CMD) begin : g_bad_ofs
      $error("register offsets must be distinct");
   end
   if ((OFS_STAT | OFS_IEN | OFS_EINFO | OFS_CMD) >= (1 << ADDR_W)) begin : g_bad_aw
      $error("register offset beyond ADDR_W");
   end

   logic wdata_unused;
   assign wdata_unused = ^reg_wdata[DATA_W-1:CMD_BITS];

   logic wr_cmd, wr_stat, wr_ien;
   assign wr_cmd  = reg_we && (reg_addr == A_CMD);
   assign wr_stat = reg_we && (reg_addr == A_STAT);
   assign wr_ien  = reg_we && (reg_addr == A_IEN);

   ch_op_e op;
   dmach_cmd_dec u_dec (
      .cmd_wr   (wr_cmd),
      .cmd_bits (reg_wdata[CMD_BITS-1:0]),
      .op       (op)
   );

   logic [N_CAUSE-1:0] cause;
   assign cause = {eng_rd_poison, eng_wr_resp_err, eng_rd_resp_err};

   ch_state_e state;
   logic st_done, st_err, st_dis, st_stp;
   logic done_evt, err_evt, start_evt;

   dmach_chan_fsm #(.RESUME_LAT(RESUME_LAT)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .op           (op),
      .eng_done     (eng_done),
      .eng_beat_end (eng_beat_end),
      .eng_err_any  (|cause),
      .state_q      (state),
      .st_done_q    (st_done),
      .st_err_q     (st_err),
      .st_dis_q     (st_dis),
      .st_stp_q     (st_stp),
      .done_evt     (done_evt),
      .err_evt      (err_evt),
      .start_evt    (start_evt),
      .start_q      (eng_start)
   );

   logic [1:0]         flags, ien;
   logic [N_CAUSE-1:0] einfo;

   dmach_irq_unit #(.IRQ_REGISTERED(IRQ_REGISTERED)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (op == OP_CLEAR),
      .done_evt  (done_evt),
      .err_evt   (err_evt),
      .start_evt (start_evt),
      .err_cause (cause),
      .ien_wr    (wr_ien),
      .ien_wdata (reg_wdata[1:0]),
      .w1c_wr    (wr_stat),
      .w1c_bits  (reg_wdata[1:0]),
      .flags_q   (flags),
      .ien_q     (ien),
      .einfo_q   (einfo),
      .irq       (irq)
   );

   assign eng_run      = (state == CH_RUN);
   assign eng_stop_req = (state == CH_STOPPING);

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == A_STAT) begin
         reg_rdata[ST_FLAG_DONE] = flags[0];
         reg_rdata[ST_FLAG_ERR]  = flags[1];
         reg_rdata[ST_DONE]      = st_done;
         reg_rdata[ST_ERR]       = st_err;
         reg_rdata[ST_DIS]       = st_dis;
         reg_rdata[ST_STOPPED]   = st_stp;
         reg_rdata[ST_PAUSED]    = (state == CH_PAUSED);
         reg_rdata[ST_RWAIT]     = (state == CH_RWAIT);
      end else if (reg_addr == A_IEN) begin
         reg_rdata[1:0] = ien;
      end else if (reg_addr == A_EINFO) begin
         reg_rdata[EI_BASE +: N_CAUSE] = einfo;
      end
   end

endmodule

// File: tb/dmach_ctl_regs_bench.sv
`timescale 1ns/1ps
module dmach_ctl_regs_bench;

   localparam int LAT = 3;
   localparam logic [7:0] A_STAT = 8'h0, A_IEN = 8'h4, A_EI = 8'h8, A_CMD = 8'hC;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [7:0]  reg_addr = A_STAT;
   logic [31:0] reg_wdata = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_rdata;
   logic        eng_start, eng_run, eng_stop_req, irq;
   logic        eng_beat_end = 0, eng_done = 0, eng_rd_resp_err = 0;
   logic        eng_wr_resp_err = 0, eng_rd_poison = 0;

   dmach_ctl_regs u_dmach_ctl_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_we(reg_we), .reg_rdata(reg_rdata), .eng_start(eng_start),
      .eng_run(eng_run), .eng_stop_req(eng_stop_req), .eng_beat_end(eng_beat_end),
      .eng_done(eng_done), .eng_rd_resp_err(eng_rd_resp_err),
      .eng_wr_resp_err(eng_wr_resp_err), .eng_rd_poison(eng_rd_poison), .irq(irq)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   // reference model: 0 idle 1 run 2 paused 3 resume-wait 4 stopping
   int ms = 0, mcnt = 0;
   bit md, me, mdis, mstp, mpend, mfd, mfe, mstart;
   bit [1:0] mien;
   bit [2:0] mei;

   always @(posedge clk) begin
      if (!rst_n) begin
         ms = 0; mcnt = 0; md = 0; me = 0; mdis = 0; mstp = 0; mpend = 0;
         mfd = 0; mfe = 0; mstart = 0; mien = 0; mei = 0;
      end else begin
         int old, opr;
         bit sd, se, st, clr;
         bit [2:0] cz;
         old = ms; sd = 0; se = 0; st = 0; clr = 0;
         cz = {eng_rd_poison, eng_wr_resp_err, eng_rd_resp_err};
         opr = 0;
         if (reg_we && reg_addr == A_CMD) begin
            if (reg_wdata[1]) opr = 2;
            else if (reg_wdata[3]) opr = 4;
            else if (reg_wdata[2]) opr = 3;
            else if (reg_wdata[4]) opr = 5;
            else if (reg_wdata[5]) opr = 6;
            else if (reg_wdata[0]) opr = 1;
         end
         if (opr == 2) begin
            clr = 1; ms = 0; mcnt = 0; md = 0; me = 0; mdis = 0; mstp = 0; mpend = 0;
         end else if (cz != 0 && (old == 1 || old == 4)) begin
            ms = 0; me = 1; se = 1; mpend = 0;
         end else if (old == 1 && eng_done) begin
            ms = 0; md = 1; sd = 1; mdis = mpend; mpend = 0;
         end else if (old == 4 && (eng_beat_end || eng_done)) begin
            ms = 0; mstp = 1;
         end else begin
            if (opr == 1 && old == 0) begin
               ms = 1; md = 0; me = 0; mdis = 0; mstp = 0; st = 1;
            end else if (opr == 4 && old == 1) begin
               ms = 4; mpend = 0;
            end else if (opr == 4 && (old == 2 || old == 3)) begin
               ms = 0; mstp = 1; mpend = 0;
            end else if (opr == 3 && (old == 1 || old == 2 || old == 3)) begin
               mpend = 1;
            end else if (opr == 5 && old == 1) begin
               ms = 2;
            end else if (opr == 6 && old == 2) begin
               ms = 3; mcnt = LAT - 1;
            end
            if (old == 3 && ms == 3) begin
               if (mcnt == 0) ms = 1; else mcnt--;
            end
         end
         mstart = st;
         if (clr) begin
            mfd = 0; mfe = 0; mien = 0; mei = 0;
         end else begin
            bit w; w = reg_we && reg_addr == A_STAT;
            if (sd) mfd = 1; else if (w && reg_wdata[0]) mfd = 0;
            if (se) mfe = 1; else if (w && reg_wdata[1]) mfe = 0;
            if (reg_we && reg_addr == A_IEN) mien = reg_wdata[1:0];
            if (st) mei = 0; else if (se) mei = mei | cz;
         end
      end
   end

   function automatic logic [31:0] exp_rd(input logic [7:0] a);
      logic [31:0] v; v = '0;
      if (a == A_STAT) begin
         v[0] = mfd; v[1] = mfe; v[16] = md; v[17] = me; v[18] = mdis;
         v[19] = mstp; v[20] = (ms == 2); v[21] = (ms == 3);
      end else if (a == A_IEN) v[1:0] = mien;
      else if (a == A_EI) v[18:16] = mei;
      return v;
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk(32'(eng_start), 32'(mstart), "R3 eng_start");
      chk(32'(eng_run), 32'(ms == 1), "R4 eng_run");
      chk(32'(eng_stop_req), 32'(ms == 4), "R6 eng_stop_req");
      chk(32'(irq), 32'((mfd & mien[0]) | (mfe & mien[1])), "R11 irq");
      chk(reg_rdata, exp_rd(reg_addr), "R10 read data");
   endtask

   task automatic tick();
      @(negedge clk);
      compare_all();
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      reg_we = 1; reg_addr = a; reg_wdata = d;
      tick();
      reg_we = 0; reg_addr = A_STAT; reg_wdata = '0;
   endtask

   task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      reg_addr = a; #1;
      chk(reg_rdata, e, tag);
      reg_addr = A_STAT;
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      expect_rd(A_STAT, 0, "R1 status");
      expect_rd(A_IEN, 0, "R1 enables");
      expect_rd(A_EI, 0, "R1 causes");
      chk(32'({eng_run, eng_stop_req, eng_start, irq}), 0, "R1 outputs");
      expect_rd(A_CMD, 0, "R2 command reads zero");
      expect_rd(8'h10, 0, "R2 unmapped");
      wr(A_IEN, 3);
      expect_rd(A_IEN, 3, "R11 enable readback");
      // R3 enable
      wr(A_CMD, 1);
      chk(32'({eng_run, eng_start}), 3, "R3 start");
      tick();
      chk(32'(eng_start), 0, "R3 single pulse");
      wr(A_CMD, 1);
      chk(32'(eng_start), 0, "R3 enable while running");
      // R4 pause
      wr(A_CMD, 32'h10);
      expect_rd(A_STAT, 32'h0010_0000, "R4 paused");
      chk(32'(eng_run), 0, "R4 run low");
      // R5 resume
      wr(A_CMD, 32'h20);
      expect_rd(A_STAT, 32'h0020_0000, "R5 resume-wait");
      tick(); tick();
      expect_rd(A_STAT, 32'h0020_0000, "R5 still waiting");
      tick();
      chk(32'(eng_run), 1, "R5 running again");
      // R8 done
      eng_done = 1; tick(); eng_done = 0;
      expect_rd(A_STAT, 32'h0001_0001, "R8 done");
      chk(32'(irq), 1, "R11 irq on done");
      wr(A_STAT, 1);
      expect_rd(A_STAT, 32'h0001_0000, "R10 w1c");
      // R7 disable
      wr(A_CMD, 1);
      expect_rd(A_STAT, 0, "R3 status cleared");
      wr(A_CMD, 4);
      chk(32'(eng_run), 1, "R7 still running");
      eng_done = 1; tick(); eng_done = 0;
      expect_rd(A_STAT, 32'h0005_0001, "R7 disabled");
      wr(A_STAT, 3);
      // R6 stop from running
      wr(A_CMD, 1);
      wr(A_CMD, 8);
      tick(); tick();
      chk(32'(eng_stop_req), 1, "R6 stop request held");
      eng_beat_end = 1; tick(); eng_beat_end = 0;
      expect_rd(A_STAT, 32'h0008_0000, "R6 stopped");
      // R6 stop from paused
      wr(A_CMD, 1); wr(A_CMD, 32'h10); wr(A_CMD, 8);
      expect_rd(A_STAT, 32'h0008_0000, "R6 stop from paused");
      wr(A_CMD, 8);
      expect_rd(A_STAT, 32'h0008_0000, "R6 stop in idle");
      // R9 errors
      wr(A_CMD, 1);
      eng_rd_resp_err = 1; eng_rd_poison = 1; tick();
      eng_rd_resp_err = 0; eng_rd_poison = 0;
      expect_rd(A_STAT, 32'h0002_0002, "R9 error status");
      expect_rd(A_EI, 32'h0005_0000, "R9 causes");
      eng_wr_resp_err = 1; tick(); eng_wr_resp_err = 0;
      expect_rd(A_EI, 32'h0005_0000, "R9 ignored in idle");
      wr(A_CMD, 1);
      expect_rd(A_EI, 0, "R9 cleared by enable");
      eng_wr_resp_err = 1; tick(); eng_wr_resp_err = 0;
      expect_rd(A_EI, 32'h0002_0000, "R9 write cause");
      wr(A_STAT, 3);
      // R2 priority
      wr(A_CMD, 1);
      wr(A_CMD, 32'h1D);
      chk(32'(eng_stop_req), 1, "R2 stop wins");
      eng_beat_end = 1; tick(); eng_beat_end = 0;
      wr(A_CMD, 32'h31);
      chk(32'(eng_run), 0, "R2 pause wins over enable");
      // R13 engine event beats command
      wr(A_CMD, 1);
      reg_we = 1; reg_addr = A_CMD; reg_wdata = 32'h10; eng_done = 1;
      tick();
      reg_we = 0; reg_addr = A_STAT; eng_done = 0;
      expect_rd(A_STAT, 32'h0001_0001, "R13 done beats pause");
      wr(A_STAT, 3);
      wr(A_CMD, 1);
      eng_done = 1; eng_wr_resp_err = 1; tick(); eng_done = 0; eng_wr_resp_err = 0;
      expect_rd(A_STAT, 32'h0002_0002, "R13 error beats done");
      wr(A_STAT, 3);
      // R10 set wins over w1c
      wr(A_CMD, 1);
      reg_we = 1; reg_addr = A_STAT; reg_wdata = 1; eng_done = 1;
      tick();
      reg_we = 0; eng_done = 0;
      expect_rd(A_STAT, 32'h0001_0001, "R10 set wins");
      // R12 clear
      wr(A_CMD, 1);
      eng_rd_poison = 1; tick(); eng_rd_poison = 0;
      wr(A_CMD, 1);
      wr(A_CMD, 2);
      expect_rd(A_STAT, 0, "R12 status");
      expect_rd(A_IEN, 0, "R12 enables");
      expect_rd(A_EI, 0, "R12 causes");
      chk(32'({eng_run, irq}), 0, "R12 outputs");
      // mixed random phase
      wr(A_IEN, 3);
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = $urandom_range(0, 99);
         reg_we = (r < 30);
         reg_addr = 8'($urandom_range(0, 4) * 4);
         reg_wdata = (reg_addr == A_CMD && $urandom_range(0, 9) > 0)
                     ? 32'(1 << $urandom_range(0, 5)) & ~32'h2 : $urandom;
         eng_done = ($urandom_range(0, 9) == 0);
         eng_beat_end = ($urandom_range(0, 3) == 0);
         eng_rd_resp_err = ($urandom_range(0, 39) == 0);
         eng_wr_resp_err = ($urandom_range(0, 39) == 0);
         eng_rd_poison = ($urandom_range(0, 39) == 0);
         tick();
      end
      reg_we = 0; eng_done = 0; eng_beat_end = 0;
      eng_rd_resp_err = 0; eng_wr_resp_err = 0; eng_rd_poison = 0;
      tick();
      report();
   end

endmodule